// File: doc/BRIEF.md
# Three-Level Walsh Chip Modulator

This transmit encoder maps data symbols onto 16-chip orthogonal Walsh sequences, one chip per clock. Each 3-bit symbol selects one of eight codes, indices 7 to 14, from the order-16 Walsh set. In dual mode two symbols are sent at once: their codes are added chip by chip into a three-level stream, which doubles throughput over single mode. At a 160 MHz chip clock this gives 10 M codes/s, so 30 Mb/s per code stream and 60 Mb/s in dual mode.

A chip counter runs freely from reset and divides time into 16-cycle symbol periods. A new symbol pair and its mode bit are taken only at the boundary of a period. When no pair is offered, the next period carries zero chips. A start marker flags chip 0 of every transmitted code, so a correlator downstream can align to the period. Each chip is computed from the code and chip indices as it is needed, and no code table is stored.

Top module: `wsh3_modulator`

## Requirements
- R1: While `rst_n` is low, `chip_out` is 0 and `chip_start` and `sym_ready` are 0. The chip counter restarts at chip 0 when reset is released.
- R2: `sym_ready` is high only on chip 15 of each 16-cycle period. The first period begins in the first cycle after reset is released, so `sym_ready` is first high in the 16th cycle.
- R3: A pair is taken at a clock edge where `sym_valid` and `sym_ready` are both high. Its codes go out on the next 16 cycles, starting with chip 0. If a pair is offered at every boundary, the periods follow one another with no gap.
- R4: Symbol value v selects Walsh code index v+7. Chip j of code i is the parity of (i AND j): parity 0 is sent as -1 and parity 1 as +1.
- R5: When the pair was taken with `dual_mode`=1, `chip_out` is the chip-wise sum of the two codes: -2, 0 or +2, as a 3-bit two's-complement value.
- R6: When the pair was taken with `dual_mode`=0, `chip_out` carries code A alone as -1 or +1, and `sym_b` has no effect.
- R7: A period that follows a boundary edge with no accepted pair outputs `chip_out`=0 on all 16 chips, and `chip_start` stays low.
- R8: `chip_start` is high on chip 0 of every transmitted period and low on every other cycle.
- R9: Changes on `sym_valid`, `sym_a`, `sym_b` or `dual_mode` while `sym_ready` is low do not change the period being sent.
- R10: Correlating the 16 chips of a period with each allowed code gives 16 times the number of transmitted codes that equal it: 32 when both dual codes are the same, and 0 for every other code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | A symbol pair is offered |
| sym_ready | output | 1 | Boundary chip: the offered pair is taken at this edge |
| sym_a | input | 3 | First symbol, always sent |
| sym_b | input | 3 | Second symbol, sent in dual mode only |
| dual_mode | input | 1 | 1: sum two codes, 0: send code A alone |
| chip_out | output | 3 | Signed chip level |
| chip_start | output | 1 | High on chip 0 of a transmitted code |

## Verification
The bench first drives directed pairs. Two equal codes in dual mode give only ±2 chips. Codes at the two ends of the allowed range and mid-range pairs give 0 chips wherever the codes differ, so the bench can tell an addition from a selection. Single mode with a random `sym_b` shows whether the second lane is truly gated off. An idle stretch and a phase where every input is scrambled on every cycle test the boundary-only sampling. A long random run mixes modes and gaps. For every period sent, the bench correlates the chips against all eight codes, and this catches a wrong index offset or chip mapping even where single chips look plausible.

// File: rtl/wsh3_pkg.sv
package wsh3_pkg;

  localparam int LANES = 2;

  // Walsh chip: parity of the AND of code index and chip index
  function automatic logic walsh_bit(input logic [31:0] code_idx,
                                     input logic [31:0] chip_idx);
    return ^(code_idx & chip_idx);
  endfunction

  // chip bit to antipodal level: 0 -> -1, 1 -> +1
  function automatic logic signed [1:0] chip_level(input logic b);
    return b ? 2'sb01 : 2'sb11;
  endfunction

endpackage

// File: rtl/wsh3_chip_seq.sv
module wsh3_chip_seq #(
  parameter int CHIP_LOG = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  output logic [CHIP_LOG-1:0] cnt,
  output logic                at_last,
  output logic                busy
);
  localparam logic [CHIP_LOG-1:0] LAST = {CHIP_LOG{1'b1}};

  assign at_last = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (at_last) busy <= take;
    end
  end

  AST_READY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    at_last |=> (cnt == '0)); // R2
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !at_last |=> $stable(busy)); // R9

endmodule

// File: rtl/wsh3_code_gen.sv
module wsh3_code_gen #(
  parameter int CHIP_LOG = 4
) (
  input  logic [CHIP_LOG-1:0] code_idx,
  input  logic [CHIP_LOG-1:0] chip_idx,
  output logic signed [1:0]   level
);
  always_comb
    level = wsh3_pkg::chip_level(wsh3_pkg::walsh_bit(32'(code_idx), 32'(chip_idx)));
endmodule

// File: rtl/wsh3_summer.sv
module wsh3_summer #(
  parameter int OUT_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    busy,
  input  logic                    dual,
  input  logic signed [1:0]       lvl_a,
  input  logic signed [1:0]       lvl_b,
  output logic signed [OUT_W-1:0] out
);
  localparam logic signed [OUT_W-1:0] POS2 = OUT_W'(2);
  localparam logic signed [OUT_W-1:0] NEG2 = -OUT_W'(2);
  localparam logic signed [OUT_W-1:0] POS1 = OUT_W'(1);
  localparam logic signed [OUT_W-1:0] NEG1 = -OUT_W'(1);

  logic signed [OUT_W-1:0] ext_a, ext_b;

  always_comb begin
    ext_a = {{(OUT_W-2){lvl_a[1]}}, lvl_a};
    ext_b = dual ? {{(OUT_W-2){lvl_b[1]}}, lvl_b} : '0;
    out   = busy ? (ext_a + ext_b) : '0;
  end

  AST_SINGLE_AMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dual) |-> (out == POS1 || out == NEG1)); // R6
  AST_DUAL_AMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dual) |-> (out == POS2 || out == NEG2 || out == '0)); // R5

endmodule

// File: rtl/wsh3_modulator.sv
module wsh3_modulator #(
  parameter int SYM_W     = 3,
  parameter int CHIP_LOG  = 4,
  parameter int CODE_BASE = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_valid,
  output logic             sym_ready,
  input  logic [SYM_W-1:0] sym_a,
  input  logic [SYM_W-1:0] sym_b,
  input  logic             dual_mode,
  output logic signed [2:0] chip_out,
  output logic             chip_start
);
  localparam int OUT_W = 3;
  localparam int LANES = wsh3_pkg::LANES;

  logic [CHIP_LOG-1:0] cnt;
  logic                at_last, busy, take;
  logic [CHIP_LOG-1:0] idx_q [LANES];
  logic [SYM_W-1:0]    sym_in [LANES];
  logic signed [1:0]   lvl [LANES];
  logic                dual_q;

  assign sym_in[0] = sym_a;
  assign sym_in[1] = sym_b;
  assign sym_ready = at_last;
  assign take      = sym_valid & at_last;

  wsh3_chip_seq #(.CHIP_LOG(CHIP_LOG)) u_seq (
    .clk(clk), .rst_n(rst_n), .take(take),
    .cnt(cnt), .at_last(at_last), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dual_q <= 1'b0;
    else if (take) dual_q <= dual_mode;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idx_q[g] <= CHIP_LOG'(CODE_BASE);
      else if (take) idx_q[g] <= CHIP_LOG'(sym_in[g]) + CHIP_LOG'(CODE_BASE);
    end
    wsh3_code_gen #(.CHIP_LOG(CHIP_LOG)) u_code (
      .code_idx(idx_q[g]), .chip_idx(cnt), .level(lvl[g])
    );
  end

  wsh3_summer #(.OUT_W(OUT_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .busy(busy), .dual(dual_q),
    .lvl_a(lvl[0]), .lvl_b(lvl[1]), .out(chip_out)
  );

  assign chip_start = busy && (cnt == '0);

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_ready) |=> chip_start); // R3
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_ready && !sym_valid) |=> (chip_out == '0 && !chip_start)); // R7
  AST_PAIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_ready |=> ($stable(idx_q[0]) && $stable(idx_q[1]) && $stable(dual_q))); // R9
  AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    chip_start |-> $past(sym_ready)); // R8

endmodule

// File: tb/sim_wsh3_modulator.sv
module sim_wsh3_modulator;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 7;
  localparam int NCHIP = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sym_valid = 1'b0, dual_mode = 1'b0;
  logic [2:0] sym_a = '0, sym_b = '0;
  logic sym_ready, chip_start;
  logic signed [2:0] chip_out;

  int vectors = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wsh3_modulator u0 (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_a(sym_a), .sym_b(sym_b), .dual_mode(dual_mode),
    .chip_out(chip_out), .chip_start(chip_start)
  );

  // recursive Walsh construction: quadrant (1,1) is the complement
  function automatic int rec_bit(int i, int j, int n);
    int half;
    if (n == 1) return 0;
    half = n / 2;
    return rec_bit(i % half, j % half, half) ^ ((i >= half && j >= half) ? 1 : 0);
  endfunction

  function automatic int lv(int code, int j);
    return rec_bit(code, j, NCHIP) ? 1 : -1;
  endfunction

  // behavioural model of period timing
  logic [3:0] m_cnt;
  logic m_busy, m_dual;
  logic [2:0] m_a, m_b;
  int rx [NCHIP];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_busy <= 1'b0; m_dual <= 1'b0; m_a <= '0; m_b <= '0;
    end else begin
      m_cnt <= m_cnt + 1'b1;
      if (m_cnt == 4'd15) begin
        m_busy <= sym_valid;
        if (sym_valid) begin m_a <= sym_a; m_b <= sym_b; m_dual <= dual_mode; end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    int exp_chip, c;
    string tag;
    chk(sym_ready == (m_cnt == 4'd15), "R2 sym_ready", int'(sym_ready), int'(m_cnt == 4'd15));
    chk(chip_start == (m_busy && m_cnt == 0), "R3 R8 chip_start", int'(chip_start),
        int'(m_busy && m_cnt == 0));
    if (!m_busy) begin exp_chip = 0; tag = "R7 idle chip"; end
    else if (m_dual) begin
      exp_chip = lv(m_a + BASE, m_cnt) + lv(m_b + BASE, m_cnt); tag = "R5 R9 dual chip";
    end else begin
      exp_chip = lv(m_a + BASE, m_cnt); tag = "R4 R6 R9 single chip";
    end
    chk(int'(chip_out) == exp_chip, tag, int'(chip_out), exp_chip);
    if (m_busy) rx[m_cnt] = int'(chip_out);
    if (m_busy && m_cnt == 4'd15) begin
      for (int k = 0; k < 8; k++) begin
        c = 0;
        for (int j = 0; j < NCHIP; j++) c += rx[j] * lv(k + BASE, j);
        exp_chip = 16 * ((k == m_a) ? 1 : 0) + ((m_dual && k == m_b) ? 16 : 0);
        chk(c == exp_chip, "R10 correlation", c, exp_chip);
      end
    end
  endtask

  task automatic step(input logic v, input logic [2:0] a, input logic [2:0] b, input logic d);
    @(negedge clk);
    check_outputs();
    sym_valid = v; sym_a = a; sym_b = b; dual_mode = d;
  endtask

  task automatic hold_pair(input logic [2:0] a, input logic [2:0] b, input logic d, input int n);
    for (int i = 0; i < n; i++) step(1'b1, a, b, d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    // R1: reset values
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(chip_out == '0, "R1 chip_out in reset", int'(chip_out), 0);
      chk(!chip_start && !sym_ready, "R1 flags in reset", int'({chip_start, sym_ready}), 0);
    end
    rst_n = 1'b1;
    // directed: same code twice, extreme codes, mid pair, single with noisy B
    hold_pair(3'd0, 3'd0, 1'b1, 32);
    hold_pair(3'd0, 3'd7, 1'b1, 32);
    hold_pair(3'd3, 3'd5, 1'b1, 32);
    hold_pair(3'd7, 3'd2, 1'b0, 16);
    hold_pair(3'd6, 3'd1, 1'b0, 16);
    // R7: idle stretch
    for (int i = 0; i < 40; i++) step(1'b0, 3'd4, 3'd4, 1'b1);
    // R9: scramble all inputs every cycle
    for (int i = 0; i < 400; i++)
      step(1'($urandom), 3'($urandom), 3'($urandom), 1'($urandom));
    // mixed random run, inputs held per period with occasional gaps
    for (int p = 0; p < 200; p++) begin
      logic v, d;
      logic [2:0] a, b;
      v = ($urandom % 5) != 0; d = 1'($urandom);
      a = 3'($urandom); b = 3'($urandom);
      for (int i = 0; i < NCHIP; i++) step(v, a, b, d);
    end
    for (int i = 0; i < 20; i++) step(1'b0, 3'd0, 3'd0, 1'b0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule